// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block shifts one byte per host write onto an I2C bus as the bus master. The byte can be a data byte, a 7-bit address followed by its read/write bit, or either half of a 10-bit address; the block does not tell these apart. A write to the transmit buffer loads the shift register, raises the buffer-full flag and restarts an internal baud counter. Eight data clocks follow, most significant bit first, and then a ninth clock in which the addressed slave answers with an acknowledge.

The serial lines are open-drain. An output enable of 1 pulls the line to 0, and an output enable of 0 lets the external pull-up raise it. After the ninth clock the block raises a sticky interrupt flag and stores the acknowledge level. It then freezes with SCL held low and SDA released until the host writes the next byte. A write that arrives while a byte is still in progress is discarded and raises a sticky collision flag. Start, stop, repeated start, receive, arbitration and slave clock stretching are handled elsewhere.

Top module: `i2c_byte_tx`

## Requirements
- R1: After reset, scl_oe=1, sda_oe=0, buf_full=0, wcol=0, irq=0, ack_stat=0 and idle=1.
- R2: A wr_en pulse while idle=1 is accepted at that clock edge. From the next cycle buf_full=1, idle=0, and the first SCL low phase has begun.
- R3: Each of the nine clocks has a low phase (scl_oe=1) of T cycles followed by a released phase (scl_oe=0) of T cycles, where T equals the reload input.
- R4: Data bits leave most significant bit first. sda_oe is the inverse of the bit value (bit 0 gives sda_oe=1). sda_oe changes only at the cycle where SCL goes low, so it is stable while SCL is released.
- R5: At the falling edge that ends the eighth clock, buf_full clears and sda_oe goes to 0 for the whole ninth clock.
- R6: The level of sda_in on the last cycle of the ninth clock's released phase is stored in ack_stat: 0 means acknowledge, 1 means no acknowledge.
- R7: When the ninth clock ends, irq is set. It stays 1 until a clr_irq pulse.
- R8: Between bytes the block holds idle=1, scl_oe=1 and sda_oe=0 for as long as no write arrives.
- R9: A wr_en pulse while idle=0 sets wcol. It leaves the byte being shifted, and its timing, unchanged.
- R10: wcol stays 1, even across later accepted writes, until a clr_wcol pulse.
- R11: A reload value of 0 is treated as 1, giving one-cycle phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the transmit buffer |
| wr_data | input | 8 | Byte to transmit |
| clr_wcol | input | 1 | Clears the collision flag |
| clr_irq | input | 1 | Clears the interrupt flag |
| reload | input | RW (8) | Half-period length T in clock cycles |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| buf_full | output | 1 | Byte loaded and not yet fully shifted |
| wcol | output | 1 | Sticky write collision flag |
| ack_stat | output | 1 | Last acknowledge level (1 = not acknowledged) |
| irq | output | 1 | Sticky byte-complete flag |
| idle | output | 1 | No byte in progress |

## Verification
The hardest case to reach from the ports is a host write that lands in the middle of a byte. It has to hit a chosen cycle inside a chosen phase, and the bench must then show that the serial waveform was not disturbed. The byte task takes a cycle index at which it fires a second write carrying the inverted byte. It then checks every sample of SCL and SDA against the original byte, so a collision that leaked into the shift register would show up as wrong bits. The acknowledge cycle is reached by having the bench's slave model pull SDA low only during the ninth clock.

// File: rtl/i2c_btx_pkg.sv
package i2c_btx_pkg;
  typedef enum logic [1:0] {
    PH_STALL = 2'd0,
    PH_LOW   = 2'd1,
    PH_HIGH  = 2'd2
  } phase_e;

  localparam int unsigned DATA_BITS = 8;
  localparam int unsigned ACK_SLOT  = DATA_BITS;
  localparam int unsigned CNT_W     = $clog2(ACK_SLOT + 1);

  // SDA enable for a data bit: pulling low sends a zero.
  function automatic logic drive_for_bit(input logic bit_val, input logic in_data);
    return in_data & ~bit_val;
  endfunction

  // Phase transition on a baud expiry.
  function automatic phase_e step_phase(input phase_e cur, input logic last_clock);
    case (cur)
      PH_LOW:  return PH_HIGH;
      PH_HIGH: return last_clock ? PH_STALL : PH_LOW;
      default: return PH_STALL;
    endcase
  endfunction
endpackage

// File: rtl/btx_baud.sv
module btx_baud #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  input  logic [RW-1:0] reload,
  output logic          tick
);
  logic [RW-1:0] cnt;
  logic [RW-1:0] top_val;

  // Count T-1 down to 0; reload of 0 behaves as 1.
  assign top_val = (reload == '0) ? '0 : reload - {{(RW-1){1'b0}}, 1'b1};
  assign tick    = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (start || tick) cnt <= top_val;
    else if (run)           cnt <= cnt - {{(RW-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/btx_shift.sv
module btx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);
  logic [W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n)     shreg <= '0;
    else if (load)  shreg <= din;
    else if (shift) shreg <= {shreg[W-2:0], 1'b0};
  end

  assign msb = shreg[W-1];
endmodule

// File: rtl/btx_flag.sv
module btx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/i2c_byte_tx.sv
module i2c_byte_tx
  import i2c_btx_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          clr_wcol,
  input  logic          clr_irq,
  input  logic [RW-1:0] reload,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          buf_full,
  output logic          wcol,
  output logic          ack_stat,
  output logic          irq,
  output logic          idle
);
  phase_e           phase;
  logic [CNT_W-1:0] bit_cnt;
  logic             tick;
  logic             msb;

  // Named internal events
  logic accept;
  logic collide;
  logic fall_edge;
  logic data_done;
  logic ack_fall;
  logic shift_pulse;

  assign idle        = (phase == PH_STALL);
  assign accept      = wr_en && idle;
  assign collide     = wr_en && !idle;
  assign fall_edge   = tick && (phase == PH_HIGH);
  assign data_done   = fall_edge && (bit_cnt == CNT_W'(DATA_BITS - 1));
  assign ack_fall    = fall_edge && (bit_cnt == CNT_W'(ACK_SLOT));
  assign shift_pulse = fall_edge && (bit_cnt < CNT_W'(DATA_BITS - 1));

  btx_baud #(.RW(RW)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .run    (!idle),
    .reload (reload),
    .tick   (tick)
  );

  btx_shift #(.W(DATA_BITS)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .shift (shift_pulse),
    .din   (wr_data),
    .msb   (msb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_STALL;
      bit_cnt <= '0;
    end else if (accept) begin
      phase   <= PH_LOW;
      bit_cnt <= '0;
    end else if (tick) begin
      phase <= step_phase(phase, bit_cnt == CNT_W'(ACK_SLOT));
      if (fall_edge && !ack_fall) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign scl_oe = (phase != PH_HIGH);
  assign sda_oe = drive_for_bit(msb, !idle && (bit_cnt < CNT_W'(DATA_BITS)));

  btx_flag u_bf (
    .clk(clk), .rst_n(rst_n), .set(accept), .clr(data_done), .q(buf_full)
  );
  btx_flag u_wcol (
    .clk(clk), .rst_n(rst_n), .set(collide), .clr(clr_wcol), .q(wcol)
  );
  btx_flag u_irq (
    .clk(clk), .rst_n(rst_n), .set(ack_fall), .clr(clr_irq), .q(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        ack_stat <= 1'b0;
    else if (ack_fall) ack_stat <= sda_in;
  end
endmodule

// File: rtl/btx_checker.sv
module btx_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic sda_in,
  input logic scl_oe,
  input logic sda_oe,
  input logic buf_full,
  input logic wcol,
  input logic ack_stat,
  input logic irq,
  input logic idle,
  input logic fall_edge,
  input logic ack_fall
);
  assert_sda_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe)) |-> (sda_oe == $past(sda_oe)));

  assert_fall_drives_scl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_edge |=> scl_oe);

  assert_bf_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_full) |-> (scl_oe && !sda_oe));

  assert_ack_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fall |=> (ack_stat == $past(sda_in)));

  assert_irq_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> idle);

  assert_stall_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (scl_oe && !sda_oe));

  assert_collision_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !idle) |=> wcol);
endmodule

bind i2c_byte_tx btx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .sda_in    (sda_in),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .buf_full  (buf_full),
  .wcol      (wcol),
  .ack_stat  (ack_stat),
  .irq       (irq),
  .idle      (idle),
  .fall_edge (fall_edge),
  .ack_fall  (ack_fall)
);

// File: tb/i2c_byte_tx_test.sv
module i2c_byte_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       clr_wcol = 1'b0;
  logic       clr_irq = 1'b0;
  logic [7:0] reload = 8'd2;
  logic       slave_pull = 1'b0;
  logic       sda_in;
  logic       scl_oe, sda_oe, buf_full, wcol, ack_stat, irq, idle;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  // Wired-AND bus with external pull-up
  assign sda_in = ~(sda_oe | slave_pull);

  i2c_byte_tx #(.RW(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .clr_wcol(clr_wcol), .clr_irq(clr_irq), .reload(reload), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .buf_full(buf_full), .wcol(wcol),
    .ack_stat(ack_stat), .irq(irq), .idle(idle)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  // Sends one byte and checks every cycle; coll_at >= 0 fires a colliding write.
  task automatic send_byte(input logic [7:0] d, input int rl, input bit ack,
                           input int coll_at);
    int t = (rl == 0) ? 1 : rl;
    int scl_bad = 0, sda_bad = 0, bf_bad = 0, idle_bad = 0, idx = 0;
    @(negedge clk);
    reload = rl[7:0]; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    for (int p = 0; p < 18; p++) begin
      for (int c = 0; c < t; c++) begin
        if (p == 16 && c == 0) slave_pull = ack;
        if (scl_oe !== (p % 2 == 0)) scl_bad++;
        if (sda_oe !== ((p < 16) ? ~d[7 - p/2] : 1'b0)) sda_bad++;
        if (buf_full !== (p < 16)) bf_bad++;
        if (idle !== 1'b0) idle_bad++;
        wr_en   = (idx == coll_at);
        wr_data = (idx == coll_at) ? ~d : d;
        idx++;
        @(negedge clk);
        wr_en = 1'b0;
      end
    end
    slave_pull = 1'b0;
    check(scl_bad == 0, "R3", "SCL phase errors", scl_bad, 0);
    check(sda_bad == 0, "R4", "SDA bit errors (MSB first, R9 if collided)", sda_bad, 0);
    check(bf_bad == 0, "R5", "buf_full errors", bf_bad, 0);
    check(idle_bad == 0, "R2", "idle during byte", idle_bad, 0);
    check(idle === 1'b1, "R8", "idle after ninth clock", idle, 1);
    check(scl_oe === 1'b1 && sda_oe === 1'b0, "R8", "stall lines", {scl_oe, sda_oe}, 2);
    check(irq === 1'b1, "R7", "irq after byte", irq, 1);
    check(ack_stat === !ack, "R6", "ack_stat", ack_stat, !ack);
    if (coll_at >= 0) check(wcol === 1'b1, "R9", "wcol after collision", wcol, 1);
  endtask

  task automatic clear_irq();
    @(negedge clk); clr_irq = 1'b1;
    @(negedge clk); clr_irq = 1'b0;
    check(irq === 1'b0, "R7", "irq cleared", irq, 0);
  endtask

  task automatic test_reset();
    check(scl_oe === 1'b1 && sda_oe === 1'b0, "R1", "reset lines", {scl_oe, sda_oe}, 2);
    check(buf_full === 1'b0 && wcol === 1'b0, "R1", "reset bf/wcol", {buf_full, wcol}, 0);
    check(irq === 1'b0 && ack_stat === 1'b0, "R1", "reset irq/ack", {irq, ack_stat}, 0);
    check(idle === 1'b1, "R1", "reset idle", idle, 1);
  endtask

  task automatic test_irq_sticky();
    repeat (5) @(negedge clk);
    check(irq === 1'b1, "R7", "irq held without clear", irq, 1);
    clear_irq();
  endtask

  task automatic test_stall_hold();
    int bad = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (!(idle === 1'b1 && scl_oe === 1'b1 && sda_oe === 1'b0)) bad++;
    end
    check(bad == 0, "R8", "stall not held", bad, 0);
  endtask

  task automatic test_collision();
    send_byte(8'h81, 4, 1'b1, 21);
    clear_irq();
    send_byte(8'h5A, 2, 1'b1, -1);
    check(wcol === 1'b1, "R10", "wcol kept over accepted write", wcol, 1);
    clear_irq();
    @(negedge clk); clr_wcol = 1'b1;
    @(negedge clk); clr_wcol = 1'b0;
    check(wcol === 1'b0, "R10", "wcol cleared", wcol, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    send_byte(8'hA5, 3, 1'b1, -1);
    test_irq_sticky();
    send_byte(8'h3C, 1, 1'b0, -1);
    clear_irq();
    test_stall_hold();
    send_byte(8'hF0, 5, 1'b1, -1);
    clear_irq();
    test_collision();
    send_byte(8'h6E, 0, 1'b0, -1);   // R11: reload 0 acts as 1
    clear_irq();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule